// File: doc/BRIEF.md
# Sideband message port bridge

This block gives a host, which only has a small I/O port space, a way to run single-dword reads and writes on internal sideband endpoints. The host selects a configuration register through an indirect address port at I/O 0xCF8 and then accesses it through a data port at I/O 0xCFC. Two bridge registers are reachable this way, a control register and a data register. A write to the control register is itself the trigger for a sideband transaction. For a write transaction the payload must already be in the data register at that moment. For a read transaction the returned word lands in the data register.

The sideband side is modelled inside the block as a fixed request/response delay of `SB_LAT` cycles toward a set of endpoint register files. Each endpoint holds 256 words of 32 bits. The default build has two endpoints, at port IDs 0x03 and 0x05. While a transaction is outstanding, any host access to either bridge register is held off through `io_ready`.

Top module: `sb_msg_bridge`

## Requirements
- R1: The 32-bit configuration address register is written and read in full at I/O address 0xCF8. Its reset value is 0.
- R2: The data port at 0xCFC reaches the control register when the address register has bit 31 set, bits 23:8 (bus, device, function) at zero and offset bits 7:0 equal to 0xD0. It reaches the data register under the same conditions with offset 0xD4. Any other data-port access reads 0xFFFFFFFF, and a write to it changes nothing.
- R3: The control word is laid out as opcode [31:24], port ID [23:16], register [15:8] and byte enables [7:4]. A read of the control register returns the last control word that was accepted. Both bridge registers reset to 0.
- R4: Opcode 0x11 writes the current data register contents into the selected endpoint register. Only the bytes whose enable is set are updated, where enable bit 4 covers data bits 7:0 and enable bit 7 covers data bits 31:24.
- R5: Opcode 0x10 reads the selected endpoint register. When the transaction completes, the data register holds that value.
- R6: A control write with any other opcode is ignored. No transaction starts, and neither the control register nor the data register changes.
- R7: A transaction stays pending for `SB_LAT` cycles after the control write is accepted. During that time `io_ready` is low for any host access to a bridge register, so a data register read after a read launch stalls until the response is available.
- R8: The endpoints at port IDs 0x03 and 0x05 are separate register files that reset to zero. A write to any other port ID is dropped, and a read from any other port ID returns 0xFFFFFFFF.
- R9: A host access to an I/O address other than 0xCF8 or 0xCFC reads 0xFFFFFFFF, and a write to it is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | Host I/O address |
| io_wr | input | 1 | Host write strobe, completes on a clock edge while io_ready is high |
| io_rd | input | 1 | Host read strobe, data valid while io_ready is high |
| io_wdata | input | 32 | Host write data |
| io_rdata | output | 32 | Host read data |
| io_ready | output | 1 | Low while a bridge-register access must wait for a pending transaction |

## Verification
The assertions assume the host holds its address, strobes and write data steady while `io_ready` is low. They also assume the host never raises read and write together. The bench keeps to this because every access is driven by a single task: the task sets the inputs once on a falling edge and keeps them fixed until the access is accepted. Every access is either a write or a read, never both. The assertions also assume that a transaction is only ever started from the idle state. That follows from the hold-off, and the bench provokes it on purpose by issuing a data register read right after launching a read transaction.

// File: rtl/sb_msg_bridge.sv
module sb_msg_bridge #(
  parameter int          SB_LAT  = 3,
  parameter int          NUM_EP  = 2,
  parameter int          EP_WORDS = 256,
  parameter logic [NUM_EP*8-1:0] EP_IDS = {8'h05, 8'h03}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] io_addr,
  input  logic        io_wr,
  input  logic        io_rd,
  input  logic [31:0] io_wdata,
  output logic [31:0] io_rdata,
  output logic        io_ready
);
  localparam int CW = $clog2(SB_LAT + 1);
  localparam int IW = (NUM_EP > 1) ? $clog2(NUM_EP) : 1;
  localparam logic [7:0] OP_RD = 8'h10;
  localparam logic [7:0] OP_WR = 8'h11;

  logic [31:0] cfg_addr, ctl_q, dat_q;
  logic        busy;
  logic [CW-1:0] cnt;
  logic [31:0] ep_mem [NUM_EP][EP_WORDS];

  wire addr_hit = io_addr == 16'hCF8;
  wire data_hit = io_addr == 16'hCFC;
  wire cfg_ok   = cfg_addr[31] && (cfg_addr[23:8] == 16'h0);
  wire ctl_sel  = data_hit && cfg_ok && (cfg_addr[7:0] == 8'hD0);
  wire dat_sel  = data_hit && cfg_ok && (cfg_addr[7:0] == 8'hD4);
  wire brg_acc  = (ctl_sel || dat_sel) && (io_wr || io_rd);

  assign io_ready = !(busy && brg_acc);

  wire       acc_wr = io_wr && io_ready;
  wire [7:0] new_op = io_wdata[31:24];
  wire       launch = acc_wr && ctl_sel && (new_op == OP_RD || new_op == OP_WR);
  wire       done   = busy && (cnt == '0);

  wire [7:0] ctl_port = ctl_q[23:16];
  wire [7:0] ctl_reg  = ctl_q[15:8];
  wire [3:0] ctl_be   = ctl_q[7:4];

  logic          ep_hit;
  logic [IW-1:0] ep_idx;
  always_comb begin
    ep_hit = 1'b0;
    ep_idx = '0;
    for (int k = 0; k < NUM_EP; k++)
      if (EP_IDS[k*8 +: 8] == ctl_port) begin
        ep_hit = 1'b1;
        ep_idx = IW'(k);
      end
  end

  wire [31:0] ep_rd = ep_hit ? ep_mem[ep_idx][ctl_reg] : 32'hFFFF_FFFF;

  always_comb begin
    io_rdata = 32'hFFFF_FFFF;
    if (addr_hit)     io_rdata = cfg_addr;
    else if (ctl_sel) io_rdata = ctl_q;
    else if (dat_sel) io_rdata = dat_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_addr <= '0;
      ctl_q    <= '0;
      dat_q    <= '0;
      busy     <= 1'b0;
      cnt      <= '0;
    end else begin
      if (acc_wr && addr_hit) cfg_addr <= io_wdata;
      if (acc_wr && dat_sel)  dat_q    <= io_wdata;
      if (launch) begin
        ctl_q <= io_wdata;
        busy  <= 1'b1;
        cnt   <= CW'(SB_LAT - 1);
      end else if (done) begin
        busy <= 1'b0;
        if (ctl_q[31:24] == OP_RD) dat_q <= ep_rd;
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_EP; k++)
        for (int w = 0; w < EP_WORDS; w++)
          ep_mem[k][w] <= '0;
    end else if (done && ctl_q[31:24] == OP_WR && ep_hit) begin
      for (int b = 0; b < 4; b++)
        if (ctl_be[b]) ep_mem[ep_idx][ctl_reg][b*8 +: 8] <= dat_q[b*8 +: 8];
    end
  end

  p_ctl_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ctl_q));
  p_mdr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0) |=> $stable(dat_q));
  p_rd_return_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ctl_q[31:24] == OP_RD) |=> (dat_q == $past(ep_rd)));
  p_valid_op_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (ctl_q[31:24] == OP_RD || ctl_q[31:24] == OP_WR));
  p_cnt_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt < CW'(SB_LAT)));
  p_stall_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !io_ready |-> busy);
endmodule

// File: tb/sb_msg_bridge_bench.sv
`timescale 1ns/1ps
module sb_msg_bridge_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [31:0] io_wdata = '0;
  logic [31:0] io_rdata;
  logic        io_ready;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  sb_msg_bridge u_sb_msg_bridge (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic io_acc(input logic wr, input logic [15:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int waits);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = wr; io_rd = !wr;
    waits = 0;
    #1;
    while (!io_ready) begin
      waits++;
      @(negedge clk);
      #1;
    end
    rd = io_rdata;
    @(posedge clk);
    #1 io_wr = 1'b0; io_rd = 1'b0;
  endtask

  task automatic wr_io(input logic [15:0] a, input logic [31:0] d);
    logic [31:0] r; int w;
    io_acc(1'b1, a, d, r, w);
  endtask

  task automatic rd_io(input logic [15:0] a, output logic [31:0] r, output int w);
    io_acc(1'b0, a, '0, r, w);
  endtask

  task automatic sel(input logic [7:0] off);
    wr_io(16'hCF8, 32'h8000_0000 | off);
  endtask

  task automatic sb_write(input logic [7:0] port, input logic [7:0] rg, input logic [3:0] be,
                          input logic [31:0] d);
    sel(8'hD4); wr_io(16'hCFC, d);
    sel(8'hD0); wr_io(16'hCFC, {8'h11, port, rg, be, 4'h0});
  endtask

  task automatic sb_read(input logic [7:0] port, input logic [7:0] rg,
                         output logic [31:0] r, output int w);
    sel(8'hD0); wr_io(16'hCFC, {8'h10, port, rg, 8'hF0});
    sel(8'hD4); rd_io(16'hCFC, r, w);
  endtask

  task automatic t_reset;
    logic [31:0] r; int w;
    rd_io(16'hCF8, r, w);  chk("R1 reset addr", r, 32'h0);
    sel(8'hD4); rd_io(16'hCFC, r, w); chk("R3 reset data reg", r, 32'h0);
    wr_io(16'hCF8, 32'h8000_00D0); rd_io(16'hCF8, r, w); chk("R1 addr readback", r, 32'h8000_00D0);
    rd_io(16'hCFC, r, w); chk("R3 reset control reg", r, 32'h0);
  endtask

  task automatic t_writes;
    logic [31:0] r; int w;
    sb_write(8'h05, 8'h82, 4'hF, 32'h1000_0080);
    sb_write(8'h03, 8'h08, 4'hF, 32'h9008_0000);
    sel(8'hD0); rd_io(16'hCFC, r, w); chk("R3 control readback", r, 32'h1103_08F0);
    sb_read(8'h05, 8'h82, r, w); chk("R4 port5 reg82", r, 32'h1000_0080);
    sb_read(8'h03, 8'h08, r, w); chk("R4 port3 reg08", r, 32'h9008_0000);
    sb_read(8'h03, 8'h82, r, w); chk("R8 endpoints separate", r, 32'h0);
  endtask

  task automatic t_byte_en;
    logic [31:0] r; int w;
    sb_write(8'h03, 8'h10, 4'hF, 32'h1111_1111);
    sb_write(8'h03, 8'h10, 4'h5, 32'hAABB_CCDD);
    sb_read(8'h03, 8'h10, r, w); chk("R4 byte enables", r, 32'h11BB_11DD);
  endtask

  task automatic t_stall;
    logic [31:0] r; int w;
    sb_read(8'h05, 8'h82, r, w);
    chk("R7 data read stalled", (w > 0) ? 32'd1 : 32'd0, 32'd1);
    chk("R5 read return", r, 32'h1000_0080);
  endtask

  task automatic t_bad_op;
    logic [31:0] r; int w;
    sel(8'hD4); wr_io(16'hCFC, 32'h5A5A_0001);
    sel(8'hD0); wr_io(16'hCFC, 32'h2205_82F0);
    rd_io(16'hCFC, r, w);
    chk("R6 no stall after bad op", w, 0);
    chk("R6 control unchanged", r, 32'h1005_82F0);
    sel(8'hD4); rd_io(16'hCFC, r, w); chk("R6 data unchanged", r, 32'h5A5A_0001);
    sb_read(8'h05, 8'h82, r, w); chk("R6 endpoint untouched", r, 32'h1000_0080);
  endtask

  task automatic t_decode;
    logic [31:0] r; int w;
    sel(8'hD4); wr_io(16'hCFC, 32'h0000_CAFE);
    wr_io(16'hCF8, 32'h0000_00D4); rd_io(16'hCFC, r, w); chk("R2 disabled read", r, 32'hFFFF_FFFF);
    wr_io(16'hCFC, 32'h1234_5678);
    wr_io(16'hCF8, 32'h8000_08D4); rd_io(16'hCFC, r, w); chk("R2 wrong device", r, 32'hFFFF_FFFF);
    wr_io(16'hCF8, 32'h8000_00C4); rd_io(16'hCFC, r, w); chk("R2 wrong offset", r, 32'hFFFF_FFFF);
    sel(8'hD4); rd_io(16'hCFC, r, w); chk("R2 write dropped", r, 32'h0000_CAFE);
    wr_io(16'h0080, 32'h0);
    rd_io(16'h0080, r, w); chk("R9 other io", r, 32'hFFFF_FFFF);
    rd_io(16'hCF8, r, w); chk("R9 addr reg kept", r, 32'h8000_00D4);
  endtask

  task automatic t_no_port;
    logic [31:0] r; int w;
    sb_write(8'h07, 8'h01, 4'hF, 32'hDEAD_BEEF);
    sb_read(8'h07, 8'h01, r, w); chk("R8 absent port read", r, 32'hFFFF_FFFF);
    sb_read(8'h03, 8'h01, r, w); chk("R8 absent write dropped", r, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_writes();
    t_byte_en();
    t_stall();
    t_bad_op();
    t_decode();
    t_no_port();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule